// File: doc/BRIEF.md
# Ternary Multiply-Accumulate Engine

This block multiplies two unbalanced base-3 operands and sums the products into a running total. Each operand digit (trit) is held in its own 2-bit field, so a DIGITS-trit operand occupies 2*DIGITS bits and the total occupies 4*DIGITS bits. A sequence of operand pairs forms one run. On the first accepted pair of a run the product is added to an external bias. On each later accepted pair it is added to the registered total. The result is therefore bias plus the sum of all products of the run.

The MERGED parameter selects between two builds. The separate build forms the full product and then adds it in a 2*DIGITS-trit ripple adder. The merged build feeds the low DIGITS-1 trits of the addend into the vacant low corner of the multiplier array, so the final adder only spans the upper DIGITS+1 trits. The PIPE parameter adds one register stage ahead of the addition. Both builds give the same numbers.

Top module: `tmac_top`

## Requirements
- R1: Trit code 2'b00 is 0, 2'b01 is 1 and 2'b10 is 2. Trit k of any operand or of the result sits at bits [2k+1:2k]. Trit 0 is least significant.
- R2: An accepted cycle with first_i high sets the total to b_i + x_i*w_i, taken modulo 3^(2*DIGITS).
- R3: An accepted cycle with first_i low sets the total to the previous total + x_i*w_i, modulo 3^(2*DIGITS).
- R4: While vld_i is low, first_i, x_i, w_i and b_i are ignored. The total on y_o holds and vld_o stays low.
- R5: vld_o pulses exactly once for each accepted cycle. It rises 1 clock after the accepted edge when PIPE=0 and 2 clocks after it when PIPE=1, and back-to-back inputs are accepted every cycle.
- R6: When an addition carries out of the top trit, the total wraps and ovf_o goes high. ovf_o stays high until the next accepted first cycle, which re-evaluates it. ovf_o changes only together with vld_o.
- R7: The code 2'b11 in x_i or w_i, or in b_i on a first cycle, counts as 0 in the arithmetic. It raises err_o for that one result. A bad b_i on a non-first cycle has no effect. err_o is only high together with vld_o.
- R8: The merged build (MERGED=1) produces the same totals and flags as the separate build.
- R9: After synchronous reset, y_o is 0 and vld_o, ovf_o and err_o are low.
- R10: y_o never carries the code 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| first_i | input | 1 | Marks the first pair of a run (selects the bias) |
| vld_i | input | 1 | Input pair is accepted this cycle |
| x_i | input | 2*DIGITS | Operand x, trit coded |
| w_i | input | 2*DIGITS | Operand w, trit coded |
| b_i | input | 4*DIGITS | Bias added on a first cycle, trit coded |
| y_o | output | 4*DIGITS | Registered running total, trit coded |
| vld_o | output | 1 | Total was updated by an accepted pair |
| ovf_o | output | 1 | Sticky wrap flag for the current run |
| err_o | output | 1 | Illegal trit code seen in the pair behind this result |

## Verification
Every accepted pair produces one result. With PIPE=0 the result appears one rising edge after the pair is sampled, and with PIPE=1 it appears two edges after. The bench drives both builds in parallel, each with its own latency, and the driver stamps every expected item with the cycle in which it is due. The monitor samples a quarter period after each rising edge and pops an item only when vld_o is high. It flags a result that arrives early, late or without a matching item. On cycles without a result it checks that the total has held. A direct check of raw output bits confirms the trit coding.

// File: rtl/tmac_pkg.sv
package tmac_pkg;

    typedef logic [1:0] trit_t;

    localparam trit_t T0 = 2'b00;
    localparam trit_t T1 = 2'b01;
    localparam trit_t T2 = 2'b10;

    // digit plus carry of a small base-3 sum
    typedef struct packed {
        trit_t d;
        trit_t c;
    } tpair_t;

    // control that travels with an operand pair
    typedef struct packed {
        logic vld;
        logic first;
        logic err;
    } ctl_t;

    function automatic int tval(trit_t t);
        return (t == T1) ? 1 : ((t == T2) ? 2 : 0);
    endfunction

    function automatic trit_t tenc(int v);
        trit_t r;
        case (v)
            1:       r = T1;
            2:       r = T2;
            default: r = T0;
        endcase
        return r;
    endfunction

    function automatic logic tbad(trit_t t);
        return t == 2'b11;
    endfunction

    // split a value in 0..8 into digit and carry
    function automatic tpair_t tfold(int v);
        tpair_t r;
        r.d = tenc(v % 3);
        r.c = tenc(v / 3);
        return r;
    endfunction

    function automatic tpair_t tadd(trit_t a, trit_t b, trit_t c);
        return tfold(tval(a) + tval(b) + tval(c));
    endfunction

    // single-trit product with incoming multiply carry (max 2*2+1)
    function automatic tpair_t tmulc(trit_t a, trit_t b, trit_t c);
        return tfold(tval(a) * tval(b) + tval(c));
    endfunction

endpackage

// File: rtl/tmac_ripple.sv
module tmac_ripple
    import tmac_pkg::*;
#(
    parameter int N = 10
) (
    input  trit_t [N-1:0] a,
    input  trit_t [N-1:0] b,
    input  trit_t         cin,
    output trit_t [N-1:0] s,
    output trit_t         cout
);
    trit_t [N:0] c;
    assign c[0] = cin;

    for (genvar i = 0; i < N; i++) begin : g_cell
        tpair_t t;
        assign t      = tadd(a[i], b[i], c[i]);
        assign s[i]   = t.d;
        assign c[i+1] = t.c;
    end

    assign cout = c[N];
endmodule

// File: rtl/tmac_mult.sv
module tmac_mult
    import tmac_pkg::*;
#(
    parameter int DIGITS = 5
) (
    input  trit_t [DIGITS-1:0]   x,
    input  trit_t [DIGITS-1:0]   w,
    input  trit_t [2*DIGITS-1:0] seed,
    output trit_t [2*DIGITS-1:0] p,
    output logic                 spill
);
    localparam int W = 2 * DIGITS;

    trit_t [W-1:0]      ps [0:DIGITS];
    trit_t [DIGITS-1:0] rc;

    assign ps[0] = seed;

    for (genvar r = 0; r < DIGITS; r++) begin : g_row
        trit_t [DIGITS:0] row;
        trit_t [DIGITS:0] mc;
        trit_t [W-1:0]    sh;

        assign mc[0] = T0;
        for (genvar i = 0; i < DIGITS; i++) begin : g_pp
            tpair_t t;
            assign t       = tmulc(x[i], w[r], mc[i]);
            assign row[i]  = t.d;
            assign mc[i+1] = t.c;
        end
        assign row[DIGITS] = mc[DIGITS];

        // row r lands at trit offset r; the trits below it stay free
        assign sh = {{(W-DIGITS-1){T0}}, row} << (2 * r);

        tmac_ripple #(.N(W)) row_add (
            .a    (ps[r]),
            .b    (sh),
            .cin  (T0),
            .s    (ps[r+1]),
            .cout (rc[r])
        );
    end

    assign p     = ps[DIGITS];
    assign spill = |rc;
endmodule

// File: rtl/tmac_top.sv
module tmac_top
    import tmac_pkg::*;
#(
    parameter int DIGITS = 5,
    parameter bit MERGED = 1'b0,
    parameter bit PIPE   = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  first_i,
    input  logic                  vld_i,
    input  logic [2*DIGITS-1:0]   x_i,
    input  logic [2*DIGITS-1:0]   w_i,
    input  logic [4*DIGITS-1:0]   b_i,
    output logic [4*DIGITS-1:0]   y_o,
    output logic                  vld_o,
    output logic                  ovf_o,
    output logic                  err_o
);
    localparam int W = 2 * DIGITS;
    localparam int L = DIGITS - 1;
    localparam int H = DIGITS + 1;

    trit_t [DIGITS-1:0] xs, ws;
    trit_t [W-1:0]      bs;
    logic  [DIGITS-1:0] xbad, wbad;
    logic  [W-1:0]      bbad;

    for (genvar i = 0; i < DIGITS; i++) begin : g_opnd
        assign xbad[i] = tbad(x_i[2*i +: 2]);
        assign wbad[i] = tbad(w_i[2*i +: 2]);
        assign xs[i]   = xbad[i] ? T0 : x_i[2*i +: 2];
        assign ws[i]   = wbad[i] ? T0 : w_i[2*i +: 2];
    end
    for (genvar i = 0; i < W; i++) begin : g_bias
        assign bbad[i] = tbad(b_i[2*i +: 2]);
        assign bs[i]   = bbad[i] ? T0 : b_i[2*i +: 2];
    end

    ctl_t in_ctl;
    assign in_ctl.vld   = vld_i;
    assign in_ctl.first = first_i;
    assign in_ctl.err   = (|xbad) | (|wbad) | (first_i & (|bbad));

    trit_t [W-1:0] acc_q;
    logic          vld_q, ovf_q, err_q;

    ctl_t          a_ctl;
    trit_t [W-1:0] a_b, addend, sum;
    trit_t         cout;
    logic          spill;

    // first cycle of a run takes the bias, later cycles the total
    assign addend = a_ctl.first ? a_b : acc_q;

    if (!MERGED) begin : g_split
        trit_t [W-1:0] prod_c, a_prod;
        logic          spill_c;

        tmac_mult #(.DIGITS(DIGITS)) mul_u (
            .x     (xs),
            .w     (ws),
            .seed  ('0),
            .p     (prod_c),
            .spill (spill_c)
        );

        if (PIPE) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    a_ctl  <= '0;
                    a_prod <= '0;
                    a_b    <= '0;
                    spill  <= 1'b0;
                end else begin
                    a_ctl  <= in_ctl;
                    a_prod <= prod_c;
                    a_b    <= bs;
                    spill  <= spill_c;
                end
            end
        end else begin : g_flow
            assign a_ctl  = in_ctl;
            assign a_prod = prod_c;
            assign a_b    = bs;
            assign spill  = spill_c;
        end

        tmac_ripple #(.N(W)) add_u (
            .a    (a_prod),
            .b    (addend),
            .cin  (T0),
            .s    (sum),
            .cout (cout)
        );
    end else begin : g_fold
        trit_t [DIGITS-1:0] a_x, a_w;
        trit_t [W-1:0]      seed, arr;

        if (PIPE) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    a_ctl <= '0;
                    a_x   <= '0;
                    a_w   <= '0;
                    a_b   <= '0;
                end else begin
                    a_ctl <= in_ctl;
                    a_x   <= xs;
                    a_w   <= ws;
                    a_b   <= bs;
                end
            end
        end else begin : g_flow
            assign a_ctl = in_ctl;
            assign a_x   = xs;
            assign a_w   = ws;
            assign a_b   = bs;
        end

        // low addend trits fill the free corner of the array
        assign seed = {{(W-L){T0}}, addend[L-1:0]};

        tmac_mult #(.DIGITS(DIGITS)) mul_u (
            .x     (a_x),
            .w     (a_w),
            .seed  (seed),
            .p     (arr),
            .spill (spill)
        );

        tmac_ripple #(.N(H)) add_u (
            .a    (arr[W-1:L]),
            .b    (addend[W-1:L]),
            .cin  (T0),
            .s    (sum[W-1:L]),
            .cout (cout)
        );
        assign sum[L-1:0] = arr[L-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            vld_q <= 1'b0;
            ovf_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            vld_q <= a_ctl.vld;
            err_q <= a_ctl.vld & a_ctl.err;
            if (a_ctl.vld) begin
                acc_q <= sum;
                ovf_q <= (a_ctl.first ? 1'b0 : ovf_q) | (cout != T0) | spill;
            end
        end
    end

    assign y_o   = acc_q;
    assign vld_o = vld_q;
    assign ovf_o = ovf_q;
    assign err_o = err_q;
endmodule

// File: rtl/tmac_chk.sv
module tmac_chk #(
    parameter int DIGITS = 5,
    parameter bit PIPE   = 1'b0
) (
    input logic                clk,
    input logic                rst,
    input logic                vld_i,
    input logic [4*DIGITS-1:0] y_o,
    input logic                vld_o,
    input logic                ovf_o,
    input logic                err_o
);
    localparam logic [1:0] LATV = PIPE ? 2'd2 : 2'd1;

    logic [1:0] cyc;
    always_ff @(posedge clk) begin
        if (rst)              cyc <= 2'd0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    function automatic logic has_bad(logic [4*DIGITS-1:0] v);
        logic r;
        r = 1'b0;
        for (int i = 0; i < 2*DIGITS; i++) r |= (v[2*i +: 2] == 2'b11);
        return r;
    endfunction

    // R5
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc >= LATV) |-> (vld_o == (PIPE ? $past(vld_i, 2) : $past(vld_i))));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd1 && !$stable(y_o)) |-> vld_o);

    // R6
    sticky_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd1 && (ovf_o != $past(ovf_o))) |-> vld_o);

    // R7
    err_with_result_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> vld_o);

    // R10
    legal_trit_chk: assert property (@(posedge clk) disable iff (rst)
        !has_bad(y_o));
endmodule

bind tmac_top tmac_chk #(.DIGITS(DIGITS), .PIPE(PIPE)) chk_u (
    .clk   (clk),
    .rst   (rst),
    .vld_i (vld_i),
    .y_o   (y_o),
    .vld_o (vld_o),
    .ovf_o (ovf_o),
    .err_o (err_o)
);

// File: tb/tmac_top_tb_top.sv
module tmac_top_tb_top;
    localparam int D    = 5;
    localparam int MODV = 59049;   // 3^10

    logic clk = 1'b0;
    always #10 clk = ~clk;         // 50 MHz

    logic rst, first, vld;
    logic [9:0]  x, w;
    logic [19:0] b;
    logic [19:0] y0, y1;
    logic v0, v1, o0, o1, e0, e1;

    tmac_top #(.DIGITS(D), .MERGED(1'b0), .PIPE(1'b0)) dut_i (
        .clk(clk), .rst(rst), .first_i(first), .vld_i(vld),
        .x_i(x), .w_i(w), .b_i(b),
        .y_o(y0), .vld_o(v0), .ovf_o(o0), .err_o(e0));

    tmac_top #(.DIGITS(D), .MERGED(1'b1), .PIPE(1'b1)) dut_m (
        .clk(clk), .rst(rst), .first_i(first), .vld_i(vld),
        .x_i(x), .w_i(w), .b_i(b),
        .y_o(y1), .vld_o(v1), .ovf_o(o1), .err_o(e1));

    typedef struct {
        int y;
        bit ovf;
        bit err;
        bit first;
        int due;
    } exp_t;

    exp_t q0[$];
    exp_t q1[$];

    int ncyc = 0;
    int nchk = 0;
    int nerr = 0;
    int ref_acc = 0;
    bit ref_ovf = 1'b0;
    bit mon_on = 1'b0;
    bit done = 1'b0;
    logic [19:0] last0 = '0;
    logic [19:0] last1 = '0;

    always @(posedge clk) ncyc <= ncyc + 1;

    // R1 coding: 01 -> 1, 10 -> 2, 11 counted as 0
    function automatic int dec(logic [19:0] v);
        int s = 0;
        int p = 1;
        for (int i = 0; i < 10; i++) begin
            if (v[2*i +: 2] == 2'b01) s += p;
            else if (v[2*i +: 2] == 2'b10) s += 2 * p;
            p *= 3;
        end
        return s;
    endfunction

    function automatic logic [19:0] enc(int v);
        logic [19:0] r = '0;
        int t = v;
        for (int i = 0; i < 10; i++) begin
            r[2*i +: 2] = 2'(t % 3);
            t = t / 3;
        end
        return r;
    endfunction

    function automatic bit bad(logic [19:0] v);
        bit r = 1'b0;
        for (int i = 0; i < 10; i++) r |= (v[2*i +: 2] == 2'b11);
        return r;
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    // driver: applies a pair and queues the expected result per build
    task automatic step_raw(bit f, bit v, logic [9:0] xr, logic [9:0] wr, logic [19:0] br);
        exp_t e;
        @(negedge clk);
        first = f; vld = v; x = xr; w = wr; b = br;
        if (v) begin
            ref_acc = (f ? dec(br) : ref_acc) + dec({10'b0, xr}) * dec({10'b0, wr});
            ref_ovf = (f ? 1'b0 : ref_ovf) | (ref_acc >= MODV);
            if (ref_acc >= MODV) ref_acc -= MODV;
            e.y = ref_acc;
            e.ovf = ref_ovf;
            e.err = bad({10'b0, xr}) | bad({10'b0, wr}) | (f & bad(br));
            e.first = f;
            e.due = ncyc + 1;
            q0.push_back(e);
            e.due = ncyc + 2;
            q1.push_back(e);
        end
    endtask

    task automatic step(bit f, bit v, int xv, int wv, int bv);
        logic [19:0] xe, we;
        xe = enc(xv);
        we = enc(wv);
        step_raw(f, v, xe[9:0], we[9:0], enc(bv));
    endtask

    // idle cycles drive junk with vld low (R4: must be ignored)
    task automatic idle(int n);
        for (int k = 0; k < n; k++) step(k[0], 1'b0, 100 + k, 200 - k, 5000 + k);
    endtask

    // monitor: compares results as they appear
    task automatic mon(int id, logic v, logic [19:0] y, logic o, logic e);
        exp_t t;
        bit have;
        string tag;
        tag = (id == 0) ? "split" : "R8 merged";
        if (v) begin
            have = (id == 0) ? (q0.size() > 0) : (q1.size() > 0);
            if (!have) begin
                check(1'b0, $sformatf("R5 %s spurious vld_o", tag), 1, 0);
            end else begin
                if (id == 0) t = q0.pop_front();
                else         t = q1.pop_front();
                check(ncyc == t.due, $sformatf("R5 %s latency", tag), ncyc, t.due);
                check(dec(y) == t.y,
                      $sformatf("%s %s total", t.first ? "R2" : "R3", tag), dec(y), t.y);
                check(o == t.ovf, $sformatf("R6 %s ovf_o", tag), int'(o), int'(t.ovf));
                check(e == t.err, $sformatf("R7 %s err_o", tag), int'(e), int'(t.err));
            end
            if (id == 0) last0 = y;
            else         last1 = y;
        end else begin
            check(y == ((id == 0) ? last0 : last1), $sformatf("R4 %s hold", tag),
                  dec(y), dec((id == 0) ? last0 : last1));
            if (id == 0 && q0.size() > 0 && q0[0].due < ncyc) begin
                check(1'b0, "R5 split missing vld_o", ncyc, q0[0].due);
                void'(q0.pop_front());
            end
            if (id == 1 && q1.size() > 0 && q1[0].due < ncyc) begin
                check(1'b0, "R5 R8 merged missing vld_o", ncyc, q1[0].due);
                void'(q1.pop_front());
            end
        end
    endtask

    always @(posedge clk) begin
        #5;
        if (mon_on && !rst) begin
            mon(0, v0, y0, o0, e0);
            mon(1, v1, y1, o1, e1);
        end
    end

    initial begin
        #(20 * 50000);
        check(1'b0, "R5 watchdog expired", ncyc, 0);
        finish_up();
    end

    initial begin
        rst = 1'b1; first = 1'b0; vld = 1'b0; x = '0; w = '0; b = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mon_on = 1'b1;

        // R9 reset state
        @(posedge clk); #5;
        check(y0 == '0 && !v0 && !o0 && !e0, "R9 split reset state", dec(y0), 0);
        check(y1 == '0 && !v1 && !o1 && !e1, "R9 merged reset state", dec(y1), 0);

        // R1 raw coding: 0 + 2*1 -> trit0 = 2'b10
        step(1'b1, 1'b1, 2, 1, 0);
        idle(1);
        @(posedge clk); #5;
        check(y0 == 20'h00002, "R1 split raw code", int'(y0), 2);
        check(y1 == 20'h00002, "R1 merged raw code", int'(y1), 2);

        // R2/R3 short run with bias
        step(1'b1, 1'b1, 17, 23, 100);
        step(1'b0, 1'b1, 5, 9, 0);
        step(1'b0, 1'b1, 242, 1, 7777);   // b ignored on a later cycle
        idle(3);

        // R4 gaps: first_i toggles while vld is low, then continue the run
        step(1'b0, 1'b1, 40, 41, 0);
        idle(4);
        step(1'b0, 1'b1, 2, 2, 0);

        // R5 back-to-back run
        step(1'b1, 1'b1, 1, 1, 3);
        for (int k = 0; k < 10; k++) step(1'b0, 1'b1, 20 * k + 3, 242 - 11 * k, 0);
        idle(3);

        // R6 wrap at the top, sticky, then cleared by a new run
        step(1'b1, 1'b1, 1, 1, MODV - 1);
        step(1'b0, 1'b1, 3, 4, 0);
        idle(2);
        step(1'b0, 1'b1, 0, 0, 0);
        step(1'b1, 1'b1, 242, 242, 0);
        step(1'b0, 1'b1, 242, 242, 0);
        step(1'b1, 1'b1, 10, 10, 1);
        idle(2);

        // R7 illegal codes
        step_raw(1'b1, 1'b1, 10'b00_00_00_01_11, 10'b00_00_00_00_10, enc(4));
        step_raw(1'b0, 1'b1, 10'b00_00_00_00_01, 10'b11_00_00_00_01, '0);
        step_raw(1'b0, 1'b1, 10'b00_00_00_00_10, 10'b00_00_00_00_10, 20'hFFFFF);
        step_raw(1'b1, 1'b1, 10'b00_00_00_00_10, 10'b00_00_00_00_01, 20'h0000F);
        idle(3);

        // mixed stream
        for (int k = 0; k < 400; k++)
            step($urandom_range(0, 9) == 0, $urandom_range(0, 3) != 0,
                 $urandom_range(0, 242), $urandom_range(0, 242),
                 $urandom_range(0, MODV - 1));
        idle(5);

        check(q0.size() == 0 && q1.size() == 0, "R5 all results delivered",
              q0.size() + q1.size(), 0);
        finish_up();
    end
endmodule